// File: doc/BRIEF.md
# Host-Target Mailbox Console

This peripheral gives a processor a simple channel to a host. It has two 64-bit mailbox registers. The target-to-host register carries commands from the processor. The host-to-target register carries responses back. A 32-bit bus reaches each mailbox as two halves. A command becomes valid only through an ordered pair of writes: first the low half, which is accepted only while the mailbox is empty, then the high half, which launches the command.

A launched command is decoded from its device byte (bits 63:56) and its command byte (bits 55:48). Three commands are supported:
- An exit request latches a sticky halt and an exit code.
- A put-character command sends one byte out over a valid/ready stream.
- A get-character command parks a read request until a byte arrives on the input stream.

Each response keeps the command's top 16 bits and carries the response value in bits 47:0. Any other code gets a zero response and raises an error pulse.

Top module: `hostlink_console`

## Requirements
- R1: After reset both mailboxes read zero, and tx_valid_o, halt_o, cmd_err_o and h2t_wip_o are low.
- R2: Register map, decoded from the byte address:
  - host-to-target low half at 0x0 and high half at 0x4;
  - target-to-host low half at 0x8 and high half at 0xC;
  - a read returns the addressed 32-bit half combinationally;
  - a read of any address with bits 1:0 nonzero, or with bits above 3 nonzero, returns 0.
- R3: A bus write to 0x0 loads host-to-target bits 31:0, zeroes bits 63:32 and sets h2t_wip_o. A bus write to 0x4 ORs the data into bits 63:32 and clears h2t_wip_o.
- R4: A write to 0x8 is accepted only while the whole target-to-host register is zero. Acceptance loads bits 31:0 and arms the launch. While the register is nonzero, the write is dropped and disarms the launch.
- R5: A write to 0xC while armed ORs the data into bits 63:32, launches the full 64-bit command and disarms. A write to 0xC while disarmed changes nothing.
- R6: Put character is device 1, command 1. From the cycle after launch, tx_valid_o is high with tx_data_o equal to command bits 7:0, and target-to-host stays nonzero until a cycle with tx_ready_i high. That handshake clears target-to-host and posts host-to-target = {cmd[63:48], 0x100 | char}.
- R7: Get character is device 1, command 0. It records cmd[63:48] as the pending read, clears target-to-host and leaves host-to-target unchanged.
- R8: A cycle with rx_valid_i high posts host-to-target = {pending[63:48], 0x100 | rx_data_i}. Input is always accepted.
- R9: Exit is device 0, command 0, payload bit 0 set. It sets halt_o, which stays high until reset, sets exit_code_o to cmd[47:1], posts {cmd[63:48], 48'h0} and clears target-to-host.
- R10: Two cases post {cmd[63:48], 48'h0} and clear target-to-host:
  - An unknown device or command also raises cmd_err_o for exactly one cycle.
  - Device 0, command 0 with payload bit 0 clear raises no error.
- R11: When several sources update host-to-target in one cycle, the command response wins over an input character, and both win over a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| h2t_wip_o | output | 1 | Host-to-target half-written flag |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Output byte accepted |
| tx_data_o | output | 8 | Output byte |
| rx_valid_i | input | 1 | Input byte strobe |
| rx_data_i | input | 8 | Input byte |
| halt_o | output | 1 | Sticky halt request |
| exit_code_o | output | 47 | Exit code, zero means pass |
| cmd_err_o | output | 1 | Unknown-command pulse |

## Verification
The put-character completion and an arriving input character can both target the host-to-target register in the same cycle, and a bus write to it can land there too. The bench keeps a put command stalled, then in a single cycle raises tx_ready_i and rx_valid_i and drives a bus write to 0x0. It checks that the mailbox holds the put response. A second cycle pits an input byte against a bus write alone and expects the character response. Output bytes are compared against a scoreboard queue filled when each put command is issued.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned RESP_W = 48;
  localparam int unsigned EXIT_W = RESP_W - 1;
  localparam int unsigned TAG_W  = WORD_W - RESP_W;

  localparam logic [7:0] DEV_SYS  = 8'd0;
  localparam logic [7:0] DEV_CON  = 8'd1;
  localparam logic [7:0] CMD_CALL = 8'd0;
  localparam logic [7:0] CMD_GET  = 8'd0;
  localparam logic [7:0] CMD_PUT  = 8'd1;

  typedef enum logic [2:0] {
    OP_EXIT, OP_PUTC, OP_GETC, OP_NOSYS, OP_BAD
  } op_e;

  typedef enum logic [1:0] {
    SEL_H2T_LO = 2'd0,
    SEL_H2T_HI = 2'd1,
    SEL_T2H_LO = 2'd2,
    SEL_T2H_HI = 2'd3
  } sel_e;

  function automatic logic [RESP_W-1:0] char_resp(input logic [7:0] c);
    return {{(RESP_W-9){1'b0}}, 1'b1, c};
  endfunction
endpackage

// File: rtl/hl_addr_dec.sv
module hl_addr_dec
  import hostlink_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output sel_e              sel_o
);
  logic upper_zero;

  if (ADDR_W > 4) begin : g_upper
    assign upper_zero = ~|addr_i[ADDR_W-1:4];
  end else begin : g_flat
    assign upper_zero = 1'b1;
  end

  assign hit_o = upper_zero & (addr_i[1:0] == 2'b00);
  assign sel_o = sel_e'(addr_i[3:2]);
endmodule

// File: rtl/hl_cmd_decode.sv
module hl_cmd_decode
  import hostlink_pkg::*;
(
  input  logic [7:0] dev_i,
  input  logic [7:0] cmd_i,
  input  logic       pay0_i,
  output op_e        op_o
);
  always_comb begin
    op_o = OP_BAD;
    if (dev_i == DEV_SYS) begin
      if (cmd_i == CMD_CALL) op_o = pay0_i ? OP_EXIT : OP_NOSYS;
    end else if (dev_i == DEV_CON) begin
      if (cmd_i == CMD_GET)      op_o = OP_GETC;
      else if (cmd_i == CMD_PUT) op_o = OP_PUTC;
    end
  end
endmodule

// File: rtl/hl_t2h_reg.sv
module hl_t2h_reg
  import hostlink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              keep_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] t2h_o,
  output logic [WORD_W-1:0] full_o,
  output logic              launch_o
);
  logic [WORD_W-1:0] t2h_q;
  logic              armed_q;
  logic              empty;

  assign empty    = (t2h_q == '0);
  assign full_o   = {t2h_q[WORD_W-1:HALF_W] | wdata_i, t2h_q[HALF_W-1:0]};
  assign launch_o = wr_hi_i & armed_q;
  assign t2h_o    = t2h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t2h_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_lo_i) begin
        armed_q <= empty;
        if (empty) t2h_q[HALF_W-1:0] <= wdata_i;
      end else if (launch_o) begin
        armed_q <= 1'b0;
        t2h_q   <= keep_i ? full_o : '0;
      end
      if (clear_i) t2h_q <= '0;
    end
  end
endmodule

// File: rtl/hl_h2t_reg.sv
module hl_h2t_reg
  import hostlink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              post_i,
  input  logic [WORD_W-1:0] post_val_i,
  output logic [WORD_W-1:0] h2t_o,
  output logic              wip_o
);
  logic [WORD_W-1:0] h2t_q;
  logic              wip_q;

  assign h2t_o = h2t_q;
  assign wip_o = wip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h2t_q <= '0;
      wip_q <= 1'b0;
    end else begin
      if (wr_lo_i)      wip_q <= 1'b1;
      else if (wr_hi_i) wip_q <= 1'b0;

      if (post_i)       h2t_q <= post_val_i;
      else if (wr_lo_i) h2t_q <= {{HALF_W{1'b0}}, wdata_i};
      else if (wr_hi_i) h2t_q[WORD_W-1:HALF_W] <= h2t_q[WORD_W-1:HALF_W] | wdata_i;
    end
  end
endmodule

// File: rtl/hostlink_console.sv
module hostlink_console
  import hostlink_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              h2t_wip_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              halt_o,
  output logic [46:0]       exit_code_o,
  output logic              cmd_err_o
);
  logic              hit;
  sel_e              sel;
  logic              wr_h2t_lo, wr_h2t_hi, wr_t2h_lo, wr_t2h_hi;
  logic [WORD_W-1:0] t2h_q, full_cmd, h2t;
  logic              launch;
  op_e               op;
  logic              tx_pend_q, tx_fire;
  logic [TAG_W-1:0]  pend_tag_q;
  logic              halt_q, err_q;
  logic [EXIT_W-1:0] code_q;
  logic              cmd_post, post;
  logic [WORD_W-1:0] cmd_val, post_val;

  hl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(bus_addr_i), .hit_o(hit), .sel_o(sel)
  );

  assign wr_h2t_lo = bus_we_i & hit & (sel == SEL_H2T_LO);
  assign wr_h2t_hi = bus_we_i & hit & (sel == SEL_H2T_HI);
  assign wr_t2h_lo = bus_we_i & hit & (sel == SEL_T2H_LO);
  assign wr_t2h_hi = bus_we_i & hit & (sel == SEL_T2H_HI);

  hl_t2h_reg u_t2h (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_lo_i  (wr_t2h_lo),
    .wr_hi_i  (wr_t2h_hi),
    .wdata_i  (bus_wdata_i),
    .keep_i   (op == OP_PUTC),
    .clear_i  (tx_fire),
    .t2h_o    (t2h_q),
    .full_o   (full_cmd),
    .launch_o (launch)
  );

  hl_cmd_decode u_cmd (
    .dev_i  (full_cmd[63:56]),
    .cmd_i  (full_cmd[55:48]),
    .pay0_i (full_cmd[0]),
    .op_o   (op)
  );

  assign tx_fire    = tx_pend_q & tx_ready_i;
  assign tx_valid_o = tx_pend_q;
  assign tx_data_o  = t2h_q[7:0];

  // put response completes at the handshake; other non-read ops answer at launch
  assign cmd_post = tx_fire |
                    (launch & (op == OP_EXIT || op == OP_NOSYS || op == OP_BAD));
  assign cmd_val  = tx_fire ? {t2h_q[WORD_W-1:RESP_W], char_resp(t2h_q[7:0])}
                            : {full_cmd[WORD_W-1:RESP_W], {RESP_W{1'b0}}};
  assign post     = cmd_post | rx_valid_i;
  assign post_val = cmd_post ? cmd_val : {pend_tag_q, char_resp(rx_data_i)};

  hl_h2t_reg u_h2t (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lo_i    (wr_h2t_lo),
    .wr_hi_i    (wr_h2t_hi),
    .wdata_i    (bus_wdata_i),
    .post_i     (post),
    .post_val_i (post_val),
    .h2t_o      (h2t),
    .wip_o      (h2t_wip_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_pend_q  <= 1'b0;
      pend_tag_q <= '0;
      halt_q     <= 1'b0;
      code_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= launch & (op == OP_BAD);
      if (launch && op == OP_PUTC) tx_pend_q <= 1'b1;
      else if (tx_fire)            tx_pend_q <= 1'b0;
      if (launch && op == OP_GETC) pend_tag_q <= full_cmd[WORD_W-1:RESP_W];
      if (launch && op == OP_EXIT) begin
        halt_q <= 1'b1;
        code_q <= full_cmd[RESP_W-1:1];
      end
    end
  end

  assign halt_o      = halt_q;
  assign exit_code_o = code_q;
  assign cmd_err_o   = err_q;

  always_comb begin
    bus_rdata_o = '0;
    if (hit) begin
      unique case (sel)
        SEL_H2T_LO: bus_rdata_o = h2t[HALF_W-1:0];
        SEL_H2T_HI: bus_rdata_o = h2t[WORD_W-1:HALF_W];
        SEL_T2H_LO: bus_rdata_o = t2h_q[HALF_W-1:0];
        SEL_T2H_HI: bus_rdata_o = t2h_q[WORD_W-1:HALF_W];
        default:    bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/hl_checker.sv
module hl_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_valid_i,
  input logic        tx_ready_i,
  input logic [7:0]  tx_data_i,
  input logic [63:0] t2h_i,
  input logic        halt_i,
  input logic        err_i
);
  assert_tx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && !tx_ready_i |=> tx_valid_i && $stable(tx_data_i));

  assert_tx_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |-> t2h_i != 64'h0);

  assert_tx_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_i |=> !tx_valid_i && t2h_i == 64'h0);

  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> halt_i);

  assert_err_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> !err_i);
endmodule

bind hostlink_console hl_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_i (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_i  (tx_data_o),
  .t2h_i      (t2h_q),
  .halt_i     (halt_o),
  .err_i      (cmd_err_o)
);

// File: tb/tb_hostlink_console.sv
module tb_hostlink_console;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wip, tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        halt, cmd_err;
  logic [46:0] exit_code;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_tx[$];

  always #4 clk = ~clk;

  hostlink_console #(.ADDR_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .h2t_wip_o(wip),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .halt_o(halt), .exit_code_o(exit_code), .cmd_err_o(cmd_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, {32'h0, bus_rdata}, {32'h0, exp});
  endtask

  // scoreboard monitor: each accepted byte is compared with the oldest expectation
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) chk("R6 unexpected byte", {56'h0, tx_data}, 64'hxx);
      else chk("R6 tx byte", {56'h0, tx_data}, {56'h0, exp_tx.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 h2t lo", 4'h0, 0); rd_chk("R1 h2t hi", 4'h4, 0);
    rd_chk("R1 t2h lo", 4'h8, 0); rd_chk("R1 t2h hi", 4'hC, 0);
    chk("R1 outputs", {60'h0, tx_valid, halt, cmd_err, wip}, 64'h0);

    // R3 host-side writes, R2 map
    wr(4'h0, 32'hAABBCCDD);
    rd_chk("R2 h2t lo", 4'h0, 32'hAABBCCDD);
    chk("R3 wip set", {63'h0, wip}, 64'h1);
    wr(4'h4, 32'h11000000);
    rd_chk("R3 h2t hi", 4'h4, 32'h11000000);
    chk("R3 wip clear", {63'h0, wip}, 64'h0);
    wr(4'h0, 32'h5);
    rd_chk("R3 hi zeroed", 4'h4, 0);
    rd_chk("R2 unaligned", 4'h2, 0);

    // R6 put character stalled on ready
    wr(4'h8, 32'h00000041);
    rd_chk("R4 accept lo", 4'h8, 32'h41);
    exp_tx.push_back(8'h41);
    wr(4'hC, 32'h01010000);
    chk("R6 tx valid", {63'h0, tx_valid}, 64'h1);
    chk("R6 tx data", {56'h0, tx_data}, 64'h41);
    repeat (3) @(negedge clk);
    rd_chk("R6 t2h held", 4'hC, 32'h01010000);
    wr(4'h8, 32'h99);
    rd_chk("R4 drop lo", 4'h8, 32'h41);
    wr(4'hC, 32'h000000FF);
    rd_chk("R5 ignore hi", 4'hC, 32'h01010000);
    rd_chk("R6 h2t before", 4'h0, 32'h5);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R6 tx done", {63'h0, tx_valid}, 64'h0);
    rd_chk("R6 t2h clr lo", 4'h8, 0); rd_chk("R6 t2h clr hi", 4'hC, 0);
    rd_chk("R6 resp lo", 4'h0, 32'h141); rd_chk("R6 resp hi", 4'h4, 32'h01010000);

    // R7 get character, R8 input arrival
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h01000000);
    rd_chk("R7 t2h clr", 4'hC, 0);
    rd_chk("R7 h2t kept lo", 4'h0, 32'h141);
    rd_chk("R7 h2t kept hi", 4'h4, 32'h01010000);
    rx_valid = 1'b1; rx_data = 8'h5A;
    @(negedge clk);
    rx_valid = 1'b0;
    rd_chk("R8 resp lo", 4'h0, 32'h15A); rd_chk("R8 resp hi", 4'h4, 32'h01000000);

    // R10 unknown command and unsupported call
    wr(4'h8, 32'h00000077);
    wr(4'hC, 32'h07030000);
    chk("R10 err pulse", {63'h0, cmd_err}, 64'h1);
    rd_chk("R10 resp lo", 4'h0, 0); rd_chk("R10 resp hi", 4'h4, 32'h07030000);
    rd_chk("R10 t2h clr", 4'h8, 0);
    @(negedge clk);
    chk("R10 err one cycle", {63'h0, cmd_err}, 64'h0);
    wr(4'h8, 32'h00001000);
    wr(4'hC, 32'h0);
    chk("R10 nosys no err", {63'h0, cmd_err}, 64'h0);
    rd_chk("R10 nosys resp hi", 4'h4, 0);
    rd_chk("R10 nosys t2h", 4'h8, 0);

    // R11 collisions on the host-to-target register
    wr(4'h8, 32'h00000042);
    exp_tx.push_back(8'h42);
    wr(4'hC, 32'h01010000);
    @(negedge clk);
    tx_ready = 1'b1; rx_valid = 1'b1; rx_data = 8'h33;
    bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'hDEAD;
    @(negedge clk);
    tx_ready = 1'b0; rx_valid = 1'b0; bus_we = 1'b0;
    rd_chk("R11 cmd wins lo", 4'h0, 32'h142); rd_chk("R11 cmd wins hi", 4'h4, 32'h01010000);
    rx_valid = 1'b1; rx_data = 8'h34;
    bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'hBEEF;
    @(negedge clk);
    rx_valid = 1'b0; bus_we = 1'b0;
    rd_chk("R11 rx wins lo", 4'h0, 32'h134); rd_chk("R11 rx wins hi", 4'h4, 32'h01000000);

    // R9 exit with code 21
    wr(4'h8, 32'h0000002B);
    wr(4'hC, 32'h0);
    chk("R9 halt", {63'h0, halt}, 64'h1);
    chk("R9 code", {17'h0, exit_code}, 64'd21);
    rd_chk("R9 resp lo", 4'h0, 0); rd_chk("R9 resp hi", 4'h4, 0);
    rd_chk("R9 t2h clr", 4'h8, 0);
    repeat (4) @(negedge clk);
    chk("R9 halt sticky", {63'h0, halt}, 64'h1);

    chk("R6 scoreboard drained", 64'(exp_tx.size()), 64'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule